// File: doc/BRIEF.md
# Guarded Output Pin Routing Bank

This block decides, for each of a configurable number of remappable output pins, which internal signal drives that pin. Every pin owns a 5-bit select register. A select register picks either one of eleven peripheral outputs or the pin's own port-latch value. The remaining chip logic supplies the peripheral outputs, the port latches and a lock level. The block returns the routed pin values together with a configuration-mismatch reset request.

Software changes the routing through a simple write port: address, data and a write strobe. A write only takes effect while the lock input is low. While the lock is high, a write is dropped without any indication. Each select register has a second, hidden copy. An accepted write loads both copies in the same clock cycle. The two copies are compared on every cycle. If they ever differ, for example because a disturbance flipped a storage bit, the block raises a registered mismatch reset request. That request holds until the system reset returns both copies to the latch-routing code. A test input can flip a single bit of a live register so that this detection path can be exercised.

Top module: `pin_route_bank`

## Requirements
- R1: While `rst_n` is low and after it is released, every select register and its copy hold 00000, so every pin shows its own `port_latch` bit, and `mismatch_rst` is low.
- R2: Select code 00000 and every code not listed in R3 to R6 drive the pin from its `port_latch` bit.
- R3: Codes 00001, 00010 and 11110 drive the pin from `periph` bits 0, 1 and 2 (comparators one, two and three).
- R4: Code 00011 drives the pin from `periph` bit 3 (UART transmit), and code 00100 drives it from `periph` bit 4 (UART request-to-send).
- R5: Code 01000 drives the pin from `periph` bit 5 (SPI clock), 00111 from bit 6 (SPI data out) and 01001 from bit 7 (SPI slave-select out).
- R6: Codes 10010 and 10011 drive the pin from `periph` bits 8 and 9 (output-compare channels one and two), and code 11101 drives it from bit 10 (pulse generator).
- R7: A write with `lock` low loads `wr_data` into the select register at `wr_addr` and into its copy at the same rising edge. The pin follows the new code from that edge onward.
- R8: A write with `lock` high changes neither the select register nor its copy. The routing of every pin stays as it was.
- R9: A write to an address at or above NUM_PINS changes no pin's routing.
- R10: `inj_en` high with `inj_pin` below NUM_PINS and `inj_bit` below 5 inverts that bit of the live register at the next rising edge. `mismatch_rst` is then high after the following rising edge.
- R11: Once high, `mismatch_rst` stays high through any writes and lock changes until `rst_n` goes low. Asserting `rst_n` clears it.
- R12: No sequence of writes and lock changes without fault injection ever raises `mismatch_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock | input | 1 | High blocks all register writes |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Pin index to write |
| wr_data | input | 5 | New select code |
| periph | input | 11 | Peripheral outputs, bit order as in R3 to R6 |
| port_latch | input | NUM_PINS | Default port-latch value per pin |
| inj_en | input | 1 | Test-only fault injection strobe |
| inj_pin | input | ADDR_W | Pin whose live register is disturbed |
| inj_bit | input | 3 | Bit to invert within that register |
| pin_out | output | NUM_PINS | Routed pin values |
| mismatch_rst | output | 1 | Sticky configuration-mismatch reset request |

## Verification
The bench builds the bank with NUM_PINS = 6 and the one-hot selector variant. Because six is not a power of two, the 3-bit address field can reach addresses 6 and 7, which exercises the out-of-range write path. It can also direct a fault injection at a pin that does not exist. Random writes mix listed and unlisted codes under a toggling lock, so dropped writes, accepted writes and spare codes all meet fresh peripheral and latch patterns. Directed sequences cover the two-edge timing of mismatch detection and its persistence up to reset.

// File: rtl/pin_route_pkg.sv
package pin_route_pkg;

   localparam int SEL_W = 5;
   localparam int NSRC  = 11;
   localparam int IDX_W = 4;

   typedef logic [SEL_W-1:0] sel_t;

   typedef enum logic [SEL_W-1:0] {
      SEL_LATCH   = 5'b00000,
      SEL_CMP_A   = 5'b00001,
      SEL_CMP_B   = 5'b00010,
      SEL_CMP_C   = 5'b11110,
      SEL_UTX     = 5'b00011,
      SEL_URTS    = 5'b00100,
      SEL_SCLK    = 5'b01000,
      SEL_SDOUT   = 5'b00111,
      SEL_SSEL    = 5'b01001,
      SEL_CMPR_A  = 5'b10010,
      SEL_CMPR_B  = 5'b10011,
      SEL_PULSE   = 5'b11101
   } sel_code_e;

   typedef struct packed {
      logic             hit;
      logic [IDX_W-1:0] idx;
   } src_pick_t;

   // Translate a select code into a peripheral bit index; hit=0 means latch.
   function automatic src_pick_t decode_sel(input sel_t code);
      src_pick_t p;
      p.hit = 1'b1;
      p.idx = '0;
      case (code)
         SEL_CMP_A:  p.idx = 4'd0;
         SEL_CMP_B:  p.idx = 4'd1;
         SEL_CMP_C:  p.idx = 4'd2;
         SEL_UTX:    p.idx = 4'd3;
         SEL_URTS:   p.idx = 4'd4;
         SEL_SCLK:   p.idx = 4'd5;
         SEL_SDOUT:  p.idx = 4'd6;
         SEL_SSEL:   p.idx = 4'd7;
         SEL_CMPR_A: p.idx = 4'd8;
         SEL_CMPR_B: p.idx = 4'd9;
         SEL_PULSE:  p.idx = 4'd10;
         default:    p.hit = 1'b0;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/route_cell.sv
module route_cell
   import pin_route_pkg::*;
#(
   parameter int W = SEL_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         lock,
   input  logic         wr_req,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] flip_mask,
   output logic [W-1:0] live,
   output logic [W-1:0] shadow
);

   logic         accept;
   logic [W-1:0] live_q;
   logic [W-1:0] shadow_q;
   logic [W-1:0] live_base;

   assign accept    = wr_req & ~lock;
   assign live_base = accept ? wdata : live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q   <= '0;
         shadow_q <= '0;
      end else begin
         live_q <= live_base ^ flip_mask;
         if (accept)
            shadow_q <= wdata;
      end
   end

   assign live   = live_q;
   assign shadow = shadow_q;

   // R8
   locked_live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && flip_mask == '0) |=> live_q == $past(live_q));

   // R8
   locked_shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> shadow_q == $past(shadow_q));

   // R7
   accept_loads_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !lock) |=> shadow_q == $past(wdata));

   // R7
   accept_loads_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !lock && flip_mask == '0) |=> live_q == shadow_q);

endmodule

// File: rtl/route_mux.sv
module route_mux
   import pin_route_pkg::*;
#(
   parameter bit ONEHOT = 1'b0
) (
   input  sel_t            sel,
   input  logic [NSRC-1:0] src,
   input  logic            latch,
   output logic            pin
);

   generate
      if (ONEHOT) begin : g_onehot
         src_pick_t       pick;
         logic [NSRC-1:0] oh;
         assign pick = decode_sel(sel);
         for (genvar gi = 0; gi < NSRC; gi++) begin : g_line
            assign oh[gi] = pick.hit && (pick.idx == IDX_W'(gi));
         end
         assign pin = (|(oh & src)) | (~pick.hit & latch);

         // R2
         onehot_clean_chk: assert final ($onehot0(oh));
      end else begin : g_case
         always_comb begin
            case (sel)
               SEL_CMP_A:  pin = src[0];
               SEL_CMP_B:  pin = src[1];
               SEL_CMP_C:  pin = src[2];
               SEL_UTX:    pin = src[3];
               SEL_URTS:   pin = src[4];
               SEL_SCLK:   pin = src[5];
               SEL_SDOUT:  pin = src[6];
               SEL_SSEL:   pin = src[7];
               SEL_CMPR_A: pin = src[8];
               SEL_CMPR_B: pin = src[9];
               SEL_PULSE:  pin = src[10];
               default:    pin = latch;
            endcase
         end
      end
   endgenerate

endmodule

// File: rtl/cfg_compare.sv
module cfg_compare
   import pin_route_pkg::*;
#(
   parameter int NUM_PINS = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_PINS-1:0][SEL_W-1:0] live,
   input  logic [NUM_PINS-1:0][SEL_W-1:0] shadow,
   output logic                           mismatch
);

   logic [NUM_PINS-1:0] pin_diff;
   logic                mismatch_q;

   for (genvar gp = 0; gp < NUM_PINS; gp++) begin : g_cmp
      assign pin_diff[gp] = |(live[gp] ^ shadow[gp]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mismatch_q <= 1'b0;
      else if (|pin_diff)
         mismatch_q <= 1'b1;
   end

   assign mismatch = mismatch_q;

   // R11
   mismatch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mismatch_q |=> mismatch_q);

   // R12
   mismatch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mismatch_q && pin_diff == '0) |=> !mismatch_q);

endmodule

// File: rtl/pin_route_bank.sv
module pin_route_bank
   import pin_route_pkg::*;
#(
   parameter int NUM_PINS   = 8,
   parameter bit MUX_ONEHOT = 1'b0,
   localparam int ADDR_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                lock,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [SEL_W-1:0]    wr_data,
   input  logic [NSRC-1:0]     periph,
   input  logic [NUM_PINS-1:0] port_latch,
   input  logic                inj_en,
   input  logic [ADDR_W-1:0]   inj_pin,
   input  logic [2:0]          inj_bit,
   output logic [NUM_PINS-1:0] pin_out,
   output logic                mismatch_rst
);

   if (NUM_PINS < 1) begin : g_bad_pins
      $error("pin_route_bank: NUM_PINS must be at least 1");
   end
   if (SEL_W != 5) begin : g_bad_sel
      $error("pin_route_bank: select field must be 5 bits");
   end

   logic [NUM_PINS-1:0][SEL_W-1:0] live;
   logic [NUM_PINS-1:0][SEL_W-1:0] shadow;
   logic                           inj_ok;

   assign inj_ok = inj_en && (int'(inj_bit) < SEL_W);

   for (genvar gp = 0; gp < NUM_PINS; gp++) begin : g_pin
      logic             wr_hit;
      logic [SEL_W-1:0] flip;

      assign wr_hit = wr_en && (wr_addr == ADDR_W'(gp));

      for (genvar gb = 0; gb < SEL_W; gb++) begin : g_flip
         assign flip[gb] = inj_ok && (inj_pin == ADDR_W'(gp)) && (inj_bit == 3'(gb));
      end

      route_cell #(.W(SEL_W)) i_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .lock      (lock),
         .wr_req    (wr_hit),
         .wdata     (wr_data),
         .flip_mask (flip),
         .live      (live[gp]),
         .shadow    (shadow[gp])
      );

      route_mux #(.ONEHOT(MUX_ONEHOT)) i_mux (
         .sel   (live[gp]),
         .src   (periph),
         .latch (port_latch[gp]),
         .pin   (pin_out[gp])
      );
   end

   cfg_compare #(.NUM_PINS(NUM_PINS)) i_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .live     (live),
      .shadow   (shadow),
      .mismatch (mismatch_rst)
   );

   // R10
   inject_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inj_ok && int'(inj_pin) < NUM_PINS) |=> ##1 mismatch_rst);

endmodule

// File: tb/test_pin_route_bank.sv
module test_pin_route_bank;

   localparam int CLK_PERIOD = 10;
   localparam int NP = 6;
   localparam int AW = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          lock;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [4:0]    wr_data;
   logic [10:0]   periph;
   logic [NP-1:0] port_latch;
   logic          inj_en;
   logic [AW-1:0] inj_pin;
   logic [2:0]    inj_bit;
   logic [NP-1:0] pin_out;
   logic          mismatch_rst;

   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   logic [4:0] model [NP];

   always #(CLK_PERIOD/2) clk = ~clk;

   pin_route_bank #(.NUM_PINS(NP), .MUX_ONEHOT(1'b1)) i_pin_route_bank (
      .clk(clk), .rst_n(rst_n), .lock(lock), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .periph(periph), .port_latch(port_latch),
      .inj_en(inj_en), .inj_pin(inj_pin), .inj_bit(inj_bit),
      .pin_out(pin_out), .mismatch_rst(mismatch_rst)
   );

   function automatic logic ref_pin(logic [4:0] c, logic [10:0] s, logic l);
      case (c)
         5'b00001: return s[0];
         5'b00010: return s[1];
         5'b11110: return s[2];
         5'b00011: return s[3];
         5'b00100: return s[4];
         5'b01000: return s[5];
         5'b00111: return s[6];
         5'b01001: return s[7];
         5'b10010: return s[8];
         5'b10011: return s[9];
         5'b11101: return s[10];
         default:  return l;
      endcase
   endfunction

   task automatic chk(string req, string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic check_pins(string req);
      for (int p = 0; p < NP; p++)
         chk(req, $sformatf("pin %0d code %b", p, model[p]), pin_out[p],
             ref_pin(model[p], periph, port_latch[p]));
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_write(logic [AW-1:0] a, logic [4:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      if (!lock && int'(a) < NP) model[a] = d;
      tick();
      wr_en = 1'b0;
   endtask

   logic [4:0] listed [12] = '{5'b00000, 5'b00001, 5'b00010, 5'b11110, 5'b00011,
      5'b00100, 5'b01000, 5'b00111, 5'b01001, 5'b10010, 5'b10011, 5'b11101};
   string listed_req [12] = '{"R2", "R3", "R3", "R3", "R4", "R4", "R5", "R5",
      "R5", "R6", "R6", "R6"};

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      rst_n = 1'b0; lock = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      periph = 11'h5a5; port_latch = 6'b101101; inj_en = 1'b0; inj_pin = '0; inj_bit = '0;
      for (int p = 0; p < NP; p++) model[p] = 5'b00000;
      @(negedge clk);
      @(negedge clk);
      // R1: state during reset
      check_pins("R1");
      chk("R1", "mismatch in reset", mismatch_rst, 1'b0);
      rst_n = 1'b1;
      tick();
      check_pins("R1");
      chk("R1", "mismatch after reset", mismatch_rst, 1'b0);

      // R2..R6: every listed code on pin 2 under walking patterns
      for (int k = 0; k < 12; k++) begin
         do_write(3'd2, listed[k]);
         for (int b = 0; b < 11; b++) begin
            periph = 11'(1) << b; port_latch = ~port_latch;
            #1;
            chk(listed_req[k], $sformatf("code %b walk1 bit %0d", listed[k], b),
                pin_out[2], ref_pin(listed[k], periph, port_latch[2]));
            periph = ~periph;
            #1;
            chk(listed_req[k], $sformatf("code %b walk0 bit %0d", listed[k], b),
                pin_out[2], ref_pin(listed[k], periph, port_latch[2]));
         end
      end

      // R2: spare codes route the latch
      for (int k = 0; k < 32; k++) begin
         logic [4:0] c = 5'(k);
         if (ref_pin(c, 11'h7ff, 1'b0) == 1'b0) begin
            do_write(3'd4, c);
            periph = 11'h7ff; port_latch = 6'b000000;
            #1;
            chk("R2", $sformatf("spare %b latch0", c), pin_out[4], 1'b0);
            port_latch = 6'b111111;
            #1;
            chk("R2", $sformatf("spare %b latch1", c), pin_out[4], 1'b1);
         end
      end

      // R7: new code visible right after the capturing edge
      periph = 11'b000_0010_0000; port_latch = '0;
      do_write(3'd0, 5'b01000);
      chk("R7", "pin0 follows SPI clock", pin_out[0], 1'b1);

      // R8: locked writes dropped
      lock = 1'b1;
      for (int a = 0; a < NP; a++) do_write(3'(a), 5'b11101);
      check_pins("R8");
      chk("R8", "pin0 kept SPI clock", pin_out[0], 1'b1);
      lock = 1'b0;
      tick();
      check_pins("R8");

      // R9: out-of-range addresses
      do_write(3'd6, 5'b00001);
      do_write(3'd7, 5'b00010);
      periph = '1; port_latch = '0;
      #1;
      check_pins("R9");

      // R12: random traffic, never a mismatch
      for (int it = 0; it < 400; it++) begin
         lock = ($urandom_range(0, 2) == 0);
         periph = 11'($urandom());
         port_latch = 6'($urandom());
         if ($urandom_range(0, 3) == 0) do_write(3'($urandom_range(0, 7)), 5'($urandom()));
         else if ($urandom_range(0, 1) == 0) do_write(3'($urandom_range(0, 7)), listed[$urandom_range(0, 11)]);
         else tick();
         check_pins(lock ? "R8" : "R7");
         chk("R12", "no mismatch from writes", mismatch_rst, 1'b0);
      end
      lock = 1'b0;

      // R10: out-of-range injection targets flip nothing
      inj_en = 1'b1; inj_pin = 3'd7; inj_bit = 3'd1;
      tick();
      inj_pin = 3'd1; inj_bit = 3'd6;
      tick();
      inj_en = 1'b0;
      tick();
      chk("R10", "no mismatch for invalid target", mismatch_rst, 1'b0);
      check_pins("R10");

      // R10: valid injection, two-edge detection
      inj_en = 1'b1; inj_pin = 3'd3; inj_bit = 3'd4;
      tick();
      inj_en = 1'b0;
      chk("R10", "mismatch one edge after flip", mismatch_rst, 1'b0);
      tick();
      chk("R10", "mismatch two edges after flip", mismatch_rst, 1'b1);

      // R11: sticky through writes and lock changes
      do_write(3'd3, 5'b00000);
      lock = 1'b1;
      do_write(3'd0, 5'b00001);
      lock = 1'b0;
      repeat (5) tick();
      chk("R11", "mismatch stays high", mismatch_rst, 1'b1);
      rst_n = 1'b0;
      #1;
      chk("R11", "mismatch cleared by reset", mismatch_rst, 1'b0);
      for (int p = 0; p < NP; p++) model[p] = 5'b00000;
      tick();
      rst_n = 1'b1;
      periph = '1; port_latch = 6'b010011;
      tick();
      check_pins("R11");
      chk("R11", "mismatch low after reset", mismatch_rst, 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule